// File: doc/BRIEF.md
# Vector-to-Scalar Reduction Sequencer

This block folds a group of vector elements into an accumulator held in a small register file. After a start pulse it steps through the elements of a source register group in strict element order. Each step combines one source value with the accumulator using add, AND, OR or XOR and writes the result back. The source group and the accumulator may overlap. Each step reads the register file as it stands at that moment, so an overlap behaves the same as a sequential loop.

Every element can hold one to four sub-elements. In lane mode, each sub-element position keeps its own accumulator register. In horizontal mode, the sub-elements of each element are folded together and each element gets one result. Without the reduce flag, a lane-mode run stops after the first element. A host port loads and reads the register file while the block is idle.

Top module: `vec_accum_reducer`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every register in the file reads 0.
- R2: `op` selects the fold operation: 2'b00 add (modulo 2^32), 2'b01 bitwise AND, 2'b10 bitwise OR, 2'b11 bitwise XOR.
- R3: Lane mode (`svm`=0, or `subvl_m1`=0) with `mapreduce`=1 processes elements i = 0..VL-1 in order. It performs one fold per clock, so the run takes VL·SUBVL cycles, and `busy` is 1 throughout.
- R4: Lane mode with `mapreduce`=0 processes only element 0. The run takes SUBVL cycles.
- R5: SUBVL = `subvl_m1`+1. Sub-element j of element i is register `src_reg`+i·SUBVL+j. In lane mode, lane j accumulates into register `acc_reg`+j: acc[j] = op(acc[j], src[i][j]). All register indices wrap modulo 32.
- R6: Horizontal mode (`svm`=1 and `subvl_m1`>0) processes all VL elements whatever the value of `mapreduce`. For each element i, register `acc_reg`+i receives the sub-elements folded in the order x, y, …, starting from x.
- R7: Each fold reads the current register contents. When the accumulator lies inside the source group, the result equals that of a sequential loop.
- R8: `done` is a one-cycle pulse in the cycle after the last fold, and `busy` is 0 in that cycle. For N folds, counting the start edge as edge 1, `done` is first seen after edge N+1.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored.
- R10: With VL=0, nothing is written, `busy` stays 0, and `done` pulses in the cycle after the start edge.
- R11: A `vl` value above 8 is treated as 8.
- R12: A host write (`host_we`) takes effect at the next clock edge when idle, and is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; latches the control fields |
| vl | input | 4 | Element count, 0..8 |
| subvl_m1 | input | 2 | Sub-elements per element minus one |
| svm | input | 1 | Horizontal sub-element mode |
| mapreduce | input | 1 | Continue past element 0 in lane mode |
| op | input | 2 | Fold operation code |
| acc_reg | input | 5 | Accumulator register index |
| src_reg | input | 5 | First register of the source group |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run pulse |
| host_we | input | 1 | Register-file write enable |
| host_waddr | input | 5 | Write index |
| host_wdata | input | 32 | Write data |
| host_raddr | input | 5 | Read index |
| host_rdata | output | 32 | Combinational read data |

## Verification
The embedded assertions check the following on every cycle:
- `done` is a single-cycle pulse and never coincides with `busy`.
- A run ends only through `done`.
- The element and sub-element counters stay within their latched limits.
- A zero-length start produces `done` at once.
- A start while busy leaves the latched fields unchanged.

The directed scenarios cover what only data values can show:
- the fold results for each operation code;
- the lane placement and horizontal placement of results;
- stopping after element 0 when the reduce flag is clear;
- overlap between accumulator and source;
- clamping of VL;
- host writes dropped during a run;
- the exact cycle count of each run.

// File: rtl/vec_accum_reducer.sv
module vec_accum_reducer #(
  parameter int DW     = 32,
  parameter int NREGS  = 32,
  parameter int VL_MAX = 8,
  parameter int SV_MAX = 4,
  localparam int AW    = $clog2(NREGS),
  localparam int VLW   = $clog2(VL_MAX + 1),
  localparam int SVW   = (SV_MAX > 1) ? $clog2(SV_MAX) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic [SVW-1:0] subvl_m1,
  input  logic           svm,
  input  logic           mapreduce,
  input  logic [1:0]     op,
  input  logic [AW-1:0]  acc_reg,
  input  logic [AW-1:0]  src_reg,
  output logic           busy,
  output logic           done,
  input  logic           host_we,
  input  logic [AW-1:0]  host_waddr,
  input  logic [DW-1:0]  host_wdata,
  input  logic [AW-1:0]  host_raddr,
  output logic [DW-1:0]  host_rdata
);

  logic [DW-1:0]  rf [NREGS];
  logic           busy_q, done_q, horiz_q;
  logic [1:0]     op_q;
  logic [AW-1:0]  rt_q, ptr_q;
  logic [VLW-1:0] e_q, last_e_q;
  logic [SVW-1:0] s_q, s_last_q;
  logic [DW-1:0]  hacc_q;

  function automatic logic [DW-1:0] fold(input logic [DW-1:0] a, b, input logic [1:0] sel);
    case (sel)
      2'b00:   fold = a + b;
      2'b01:   fold = a & b;
      2'b10:   fold = a | b;
      default: fold = a ^ b;
    endcase
  endfunction

  logic [VLW-1:0] vl_eff;
  logic           horiz_in;
  assign vl_eff   = (vl > VLW'(VL_MAX)) ? VLW'(VL_MAX) : vl;
  assign horiz_in = svm && (subvl_m1 != '0);

  logic [DW-1:0] src_val, lane_res, h_res, wr_data;
  logic [AW-1:0] lane_idx, h_idx, wr_addr;
  logic          last_sub, last_op, wr_en;

  assign src_val  = rf[ptr_q];
  assign lane_idx = rt_q + AW'(s_q);
  assign h_idx    = rt_q + AW'(e_q);
  assign lane_res = fold(rf[lane_idx], src_val, op_q);
  assign h_res    = (s_q == '0) ? src_val : fold(hacc_q, src_val, op_q);
  assign last_sub = (s_q == s_last_q);
  assign last_op  = last_sub && (e_q == last_e_q);
  assign wr_en    = busy_q && (!horiz_q || last_sub);
  assign wr_addr  = horiz_q ? h_idx : lane_idx;
  assign wr_data  = horiz_q ? h_res : lane_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      horiz_q  <= 1'b0;
      op_q     <= '0;
      rt_q     <= '0;
      ptr_q    <= '0;
      e_q      <= '0;
      last_e_q <= '0;
      s_q      <= '0;
      s_last_q <= '0;
      hacc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (vl_eff == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q   <= 1'b1;
            horiz_q  <= horiz_in;
            op_q     <= op;
            rt_q     <= acc_reg;
            ptr_q    <= src_reg;
            e_q      <= '0;
            s_q      <= '0;
            s_last_q <= subvl_m1;
            last_e_q <= (horiz_in || mapreduce) ? vl_eff - 1'b1 : '0;
          end
        end
      end else begin
        ptr_q  <= ptr_q + 1'b1;
        hacc_q <= h_res;
        if (last_op) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (last_sub) begin
          s_q <= '0;
          e_q <= e_q + 1'b1;
        end else begin
          s_q <= s_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wr_addr] <= wr_data;
    end else if (host_we && !busy_q) begin
      rf[host_waddr] <= host_wdata;
    end
  end

  assign host_rdata = rf[host_raddr];
  assign busy       = busy_q;
  assign done       = done_q;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  assert_end_via_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_empty_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done && !busy));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(rt_q) && $stable(last_e_q) && $stable(s_last_q)));
  assert_counter_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (s_q <= s_last_q && e_q <= last_e_q && last_e_q < VLW'(VL_MAX)));

endmodule

// File: tb/test_vec_accum_reducer.sv
`timescale 1ns/1ps
module test_vec_accum_reducer;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0]  vl = '0;
  logic [1:0]  subvl_m1 = '0, op = '0;
  logic        svm = 1'b0, mapreduce = 1'b0;
  logic [4:0]  acc_reg = '0, src_reg = '0, host_waddr = '0, host_raddr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        busy, done;

  int checks = 0, errors = 0;
  logic [31:0] m [32];

  always #2.5 clk = ~clk;

  vec_accum_reducer i_vec_accum_reducer (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl_m1(subvl_m1),
    .svm(svm), .mapreduce(mapreduce), .op(op), .acc_reg(acc_reg), .src_reg(src_reg),
    .busy(busy), .done(done), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata));

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f(input logic [31:0] a, b, input logic [1:0] s);
    case (s)
      2'b00: return a + b;
      2'b01: return a & b;
      2'b10: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    m[a] = d;
  endtask

  task automatic load_all(input logic [31:0] seed);
    for (int i = 0; i < 32; i++) host_write(i, seed * (i + 3) ^ (32'h9E3779B9 >> (i % 7)));
  endtask

  task automatic compare(input string req);
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      host_raddr = 5'(i);
      #0.1;
      check(req, host_rdata, m[i]);
    end
  endtask

  function automatic int model(input int vln, sm1, input bit sv_m, mr, input logic [1:0] o, input int rt, rb);
    int v, sv, n;
    logic [31:0] r;
    v = (vln > 8) ? 8 : vln;
    sv = sm1 + 1;
    if (v == 0) return 0;
    if (sv_m && sv > 1) begin
      for (int i = 0; i < v; i++) begin
        r = m[(rb + i * sv) % 32];
        for (int j = 1; j < sv; j++) r = f(r, m[(rb + i * sv + j) % 32], o);
        m[(rt + i) % 32] = r;
      end
      return v * sv;
    end
    n = mr ? v : 1;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < sv; j++)
        m[(rt + j) % 32] = f(m[(rt + j) % 32], m[(rb + i * sv + j) % 32], o);
    return n * sv;
  endfunction

  // disturb: 0 none, 1 extra start while busy (R9), 2 host write to reg 31 while busy (R12)
  task automatic run(input string req, input int vln, sm1, input bit sv_m, mr,
                     input logic [1:0] o, input int rt, rb, input int disturb);
    int n, cyc;
    @(negedge clk);
    start = 1'b1; vl = 4'(vln); subvl_m1 = 2'(sm1); svm = sv_m; mapreduce = mr;
    op = o; acc_reg = 5'(rt); src_reg = 5'(rb);
    n = model(vln, sm1, sv_m, mr, o, rt, rb);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      host_we = 1'b0;
      if (cyc == 1 && n > 0) check({req, " busy"}, 32'(busy), 32'd1);
      if (cyc == 1 && disturb == 1) begin
        start = 1'b1; vl = 4'd2; op = ~o; acc_reg = 5'd30; src_reg = 5'd0; mapreduce = 1'b1;
      end
      if (cyc == 1 && disturb == 2) begin
        host_we = 1'b1; host_waddr = 5'd31; host_wdata = 32'hDEADBEEF;
      end
    end while (!done && cyc < 100);
    check({req, " R8 latency"}, 32'(cyc), 32'(n + 1));
    check({req, " R8 idle at done"}, 32'(busy), 32'd0);
    @(negedge clk);
    check({req, " R8 done one cycle"}, 32'(done), 32'd0);
    compare(req);
  endtask

  task automatic t_reset_R1();
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    for (int i = 0; i < 32; i++) m[i] = '0;
    compare("R1 regs zero");
  endtask

  task automatic t_ops_R2_R3();
    for (int k = 0; k < 4; k++) begin
      load_all(32'h1234_5677 + 32'(k));
      run("R2 R3 op fold", 5, 0, 1'b0, 1'b1, 2'(k), 20, 4, 0);
    end
  endtask

  task automatic t_nomr_R4();
    load_all(32'h0BAD_F00D);
    run("R4 single element", 6, 0, 1'b0, 1'b0, 2'b00, 28, 3, 0);
    run("R4 single element vec3", 6, 2, 1'b0, 1'b0, 2'b11, 26, 8, 0);
  endtask

  task automatic t_lanes_R5();
    load_all(32'h7777_1111);
    run("R5 lanes vec2", 4, 1, 1'b0, 1'b1, 2'b00, 24, 2, 0);
    run("R5 lanes vec4 wrap", 8, 3, 1'b0, 1'b1, 2'b11, 12, 16, 0);
  endtask

  task automatic t_horiz_R6();
    load_all(32'h5555_AAAA);
    run("R6 horizontal vec3", 3, 2, 1'b1, 1'b1, 2'b00, 20, 1, 0);
    run("R6 horizontal mapreduce clear", 4, 1, 1'b1, 1'b0, 2'b10, 24, 9, 0);
  endtask

  task automatic t_alias_R7();
    load_all(32'h0000_0101);
    run("R7 acc inside source", 6, 0, 1'b0, 1'b1, 2'b00, 7, 5, 0);
    run("R7 horizontal overlap", 4, 1, 1'b1, 1'b1, 2'b11, 3, 2, 0);
  endtask

  task automatic t_vl0_R10();
    load_all(32'h4242_4242);
    run("R10 empty run", 0, 2, 1'b0, 1'b1, 2'b00, 0, 10, 0);
  endtask

  task automatic t_clamp_R11();
    load_all(32'h3141_5926);
    run("R11 vl clamp", 13, 0, 1'b0, 1'b1, 2'b00, 30, 0, 0);
  endtask

  task automatic t_busy_start_R9();
    load_all(32'h2718_2818);
    run("R9 start ignored", 5, 1, 1'b0, 1'b1, 2'b00, 26, 0, 1);
  endtask

  task automatic t_host_busy_R12();
    load_all(32'h1618_0339);
    run("R12 host write ignored", 4, 0, 1'b0, 1'b1, 2'b10, 20, 0, 2);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_ops_R2_R3();
    t_nomr_R4();
    t_lanes_R5();
    t_horiz_R6();
    t_alias_R7();
    t_vl0_R10();
    t_clamp_R11();
    t_busy_start_R9();
    t_host_busy_R12();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule